// File: doc/BRIEF.md
# Data Cache Block Invalidate Sequencer

This block carries out a privileged "invalidate one data cache block" operation. A caller hands it an effective address. The block first sends that address to an external translation and protection unit, marked as a write access. If the translation reports a protection violation, the block ends the operation with a fault code. If the address lies in a direct-store segment, the operation ends as a silent no-op. In every other case the block looks up the data cache tags with the physical line address.

On a tag hit, the block issues one write to the tag state array that sets the line to Invalid. It does not look at the state the line held before, and it has no writeback path, so dirty data is dropped. When the translation marks the page as coherency-required, the block then raises a bus broadcast request and holds it until the bus acknowledges.

Every operation ends with a one-cycle completion pulse that carries a 2-bit result code. The block accepts one operation at a time. No cache enable or lock setting gates it.

Top module: `dcinv_ctrl`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, and `done`, `xl_req`, `tag_req`, `st_we` and `bc_req` are all 0.
- R2: A request is taken only while `req_ready` is 1. A `req_valid` seen while an operation is in progress is ignored: it causes no second translation and no second `done`.
- R3: Translation comes first. `xl_req` carries the latched effective address on `xl_ea` with `xl_write` = 1, and stays high until `xl_ack`. `tag_req` never rises before the translation handshake of the same operation.
- R4: Protection faults end the operation with no tag lookup, no state write and no broadcast. The result code is 2'b01 when the block-address-translation violation input is set, even if the TLB violation input is also set. It is 2'b10 when only the TLB violation input is set.
- R5: A fault-free translation with `xl_dseg` = 1 completes with code 2'b00, and there is no tag lookup, no state write and no broadcast.
- R6: On a tag hit, `st_we` is high for exactly one cycle. During that cycle `st_state` = 2'b00 (Invalid), `st_way` = the hit way, and `st_pa` = the line address.
- R7: On a tag miss, `st_we` stays low.
- R8: On a fault-free, non-direct-store operation, `bc_req` is raised if and only if `xl_coh` was 1, on both a hit and a miss. It is held until `bc_ack`, so it stays high for the acknowledge delay plus one cycle.
- R9: `done` is high for exactly one cycle after the last handshake of the operation. A successful operation reports code 2'b00. `req_ready` returns to 1 on the following cycle.
- R10: The addresses on `tag_pa`, `st_pa` and `bc_pa` equal the translated `xl_pa` with its low `LINE_BITS` (default 5) bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start an invalidate operation |
| req_ea | input | EA_W | Effective address of the block |
| req_ready | output | 1 | High when idle and able to accept a request |
| xl_req | output | 1 | Translation request |
| xl_ea | output | EA_W | Address sent for translation |
| xl_write | output | 1 | Access kind for the protection check; always a write |
| xl_ack | input | 1 | Translation result valid |
| xl_pa | input | PA_W | Translated physical address |
| xl_coh | input | 1 | Page needs coherency broadcast |
| xl_dseg | input | 1 | Address is in a direct-store segment |
| xl_bat_viol | input | 1 | Block-address-translation protection violation |
| xl_tlb_viol | input | 1 | Page-table/TLB protection violation |
| tag_req | output | 1 | Tag lookup request |
| tag_pa | output | PA_W | Line address for the lookup |
| tag_ack | input | 1 | Lookup result valid |
| tag_hit | input | 1 | Lookup hit |
| tag_way | input | WAY_W | Hit way |
| st_we | output | 1 | Tag state write strobe |
| st_pa | output | PA_W | Line address of the write |
| st_way | output | WAY_W | Way to write |
| st_state | output | 2 | New coherence state (2'b00 = Invalid) |
| bc_req | output | 1 | Bus invalidate broadcast request |
| bc_pa | output | PA_W | Line address broadcast |
| bc_ack | input | 1 | Bus acknowledge |
| done | output | 1 | One-cycle completion pulse |
| done_code | output | 2 | 00 success, 01 BAT fault, 10 TLB fault |

## Verification
A corrupted sequencer state shows at the ports within one or two cycles, in one of three ways. A request strobe appears that the previous handshake did not allow, for example a tag lookup after a fault or a broadcast on a non-coherent page. A handshake strobe drops before its acknowledge. Or `done` repeats or never comes. A wrongly captured coherency flag, way or address shows at the state-write or broadcast ports in the same operation. The fault-priority and direct-store paths differ from the normal path only in which strobes are missing and in the code that `done` carries, so every run counts each strobe.

// File: rtl/dcinv_pkg.sv
// Shared types of the cache block invalidate sequencer.
// Assumes: 2-bit coherence state encoding with Invalid = 0.
package dcinv_pkg;
    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_BAT  = 2'b01,
        FLT_TLB  = 2'b10
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TRANSLATE,
        ST_LOOKUP,
        ST_UPDATE,
        ST_BROADCAST,
        ST_DONE
    } seq_state_e;

    localparam logic [1:0] COH_INVALID = 2'b00;
endpackage

// File: rtl/dcinv_fault_prio.sv
// Fault priority encoder: block-translation violation outranks TLB violation.
// Assumes: inputs are only meaningful while the translation acknowledge is high.
module dcinv_fault_prio
    import dcinv_pkg::*;
(
    input  logic   bat_viol,
    input  logic   tlb_viol,
    output fault_e fault
);
    // Pick the highest-ranked violation present.
    always_comb begin
        if (bat_viol)      fault = FLT_BAT;
        else if (tlb_viol) fault = FLT_TLB;
        else               fault = FLT_NONE;
    end
endmodule

// File: rtl/dcinv_xl_capture.sv
// Holds the request address and the translation/lookup results of one operation.
// Assumes: the load strobes come from the sequencer and are single-cycle.
module dcinv_xl_capture #(
    parameter int EA_W      = 32,
    parameter int PA_W      = 32,
    parameter int WAY_W     = 3,
    parameter int LINE_BITS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_ea,
    input  logic [EA_W-1:0]  ea_in,
    input  logic             load_xl,
    input  logic [PA_W-1:0]  pa_in,
    input  logic             coh_in,
    input  logic             load_way,
    input  logic [WAY_W-1:0] way_in,
    output logic [EA_W-1:0]  ea_q,
    output logic [PA_W-1:0]  line_pa_q,
    output logic             coh_q,
    output logic [WAY_W-1:0] way_q
);
    localparam logic [PA_W-1:0] LINE_MASK = ~((PA_W'(1) << LINE_BITS) - PA_W'(1));

    // Latch the effective address when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)       ea_q <= '0;
        else if (load_ea) ea_q <= ea_in;
    end

    // Latch the line-aligned physical address and coherency flag at translation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_pa_q <= '0;
            coh_q     <= 1'b0;
        end else if (load_xl) begin
            line_pa_q <= pa_in & LINE_MASK;
            coh_q     <= coh_in;
        end
    end

    // Latch the hit way for the state write.
    always_ff @(posedge clk) begin
        if (!rst_n)        way_q <= '0;
        else if (load_way) way_q <= way_in;
    end
endmodule

// File: rtl/dcinv_seq.sv
// Sequencer FSM: translate, look up, invalidate, broadcast, complete.
// Assumes: acknowledges are only sampled while the matching request is high.
module dcinv_seq
    import dcinv_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    input  logic   xl_ack,
    input  fault_e xl_fault,
    input  logic   xl_dseg,
    input  logic   tag_ack,
    input  logic   tag_hit,
    input  logic   coh_q,
    input  logic   bc_ack,
    output logic   req_ready,
    output logic   xl_req,
    output logic   tag_req,
    output logic   st_we,
    output logic   bc_req,
    output logic   done,
    output fault_e done_code,
    output logic   load_ea,
    output logic   load_xl,
    output logic   load_way
);
    seq_state_e state_q, state_d;
    fault_e     code_q;
    logic       xl_done_q;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = ST_TRANSLATE;
            ST_TRANSLATE: if (xl_ack) begin
                              if (xl_fault != FLT_NONE || xl_dseg) state_d = ST_DONE;
                              else                                 state_d = ST_LOOKUP;
                          end
            ST_LOOKUP:    if (tag_ack) begin
                              if (tag_hit)    state_d = ST_UPDATE;
                              else if (coh_q) state_d = ST_BROADCAST;
                              else            state_d = ST_DONE;
                          end
            ST_UPDATE:    state_d = coh_q ? ST_BROADCAST : ST_DONE;
            ST_BROADCAST: if (bc_ack) state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Result code: cleared on accept, set from the translation response.
    always_ff @(posedge clk) begin
        if (!rst_n)       code_q <= FLT_NONE;
        else if (load_ea) code_q <= FLT_NONE;
        else if (load_xl) code_q <= xl_fault;
    end

    // Tracks that the current operation's translation has finished.
    always_ff @(posedge clk) begin
        if (!rst_n)       xl_done_q <= 1'b0;
        else if (load_ea) xl_done_q <= 1'b0;
        else if (load_xl) xl_done_q <= 1'b1;
    end

    // Decode the handshake strobes from the state.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        xl_req    = (state_q == ST_TRANSLATE);
        tag_req   = (state_q == ST_LOOKUP);
        st_we     = (state_q == ST_UPDATE);
        bc_req    = (state_q == ST_BROADCAST);
        done      = (state_q == ST_DONE);
        done_code = code_q;
        load_ea   = req_ready && req_valid;
        load_xl   = xl_req && xl_ack;
        load_way  = tag_req && tag_ack && tag_hit;
    end

    a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> (xl_req && !req_ready));
    a_r3_xl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req && !xl_ack) |=> xl_req);
    a_r3_lookup_after_xl: assert property (@(posedge clk) disable iff (!rst_n)
        tag_req |-> xl_done_q);
    a_r4_no_lookup_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        tag_req |-> (code_q == FLT_NONE));
    a_r6_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |=> !st_we);
    a_r8_bc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_req && !bc_ack) |=> bc_req);
    a_r8_bc_only_coherent: assert property (@(posedge clk) disable iff (!rst_n)
        bc_req |-> coh_q);
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));
endmodule

// File: rtl/dcinv_ctrl.sv
// Top of the data cache block invalidate sequencer.
// Assumes: one external translation unit, one tag array port and one bus
// request/acknowledge pair; each acknowledge arrives eventually.
module dcinv_ctrl #(
    parameter int EA_W      = 32,
    parameter int PA_W      = 32,
    parameter int WAYS      = 8,
    parameter int LINE_BITS = 5,
    localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [EA_W-1:0]  req_ea,
    output logic             req_ready,
    output logic             xl_req,
    output logic [EA_W-1:0]  xl_ea,
    output logic             xl_write,
    input  logic             xl_ack,
    input  logic [PA_W-1:0]  xl_pa,
    input  logic             xl_coh,
    input  logic             xl_dseg,
    input  logic             xl_bat_viol,
    input  logic             xl_tlb_viol,
    output logic             tag_req,
    output logic [PA_W-1:0]  tag_pa,
    input  logic             tag_ack,
    input  logic             tag_hit,
    input  logic [WAY_W-1:0] tag_way,
    output logic             st_we,
    output logic [PA_W-1:0]  st_pa,
    output logic [WAY_W-1:0] st_way,
    output logic [1:0]       st_state,
    output logic             bc_req,
    output logic [PA_W-1:0]  bc_pa,
    input  logic             bc_ack,
    output logic             done,
    output logic [1:0]       done_code
);
    import dcinv_pkg::*;

    fault_e             xl_fault;
    fault_e             code_e;
    logic               load_ea, load_xl, load_way, coh_q;
    logic [PA_W-1:0]    line_pa_q;
    logic [WAY_W-1:0]   way_q;

    dcinv_fault_prio u_prio (
        .bat_viol (xl_bat_viol),
        .tlb_viol (xl_tlb_viol),
        .fault    (xl_fault)
    );

    dcinv_xl_capture #(
        .EA_W(EA_W), .PA_W(PA_W), .WAY_W(WAY_W), .LINE_BITS(LINE_BITS)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_ea   (load_ea),
        .ea_in     (req_ea),
        .load_xl   (load_xl),
        .pa_in     (xl_pa),
        .coh_in    (xl_coh),
        .load_way  (load_way),
        .way_in    (tag_way),
        .ea_q      (xl_ea),
        .line_pa_q (line_pa_q),
        .coh_q     (coh_q),
        .way_q     (way_q)
    );

    dcinv_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .xl_ack    (xl_ack),
        .xl_fault  (xl_fault),
        .xl_dseg   (xl_dseg),
        .tag_ack   (tag_ack),
        .tag_hit   (tag_hit),
        .coh_q     (coh_q),
        .bc_ack    (bc_ack),
        .req_ready (req_ready),
        .xl_req    (xl_req),
        .tag_req   (tag_req),
        .st_we     (st_we),
        .bc_req    (bc_req),
        .done      (done),
        .done_code (code_e),
        .load_ea   (load_ea),
        .load_xl   (load_xl),
        .load_way  (load_way)
    );

    // Drive the address and state outputs from the captured operation data.
    always_comb begin
        xl_write  = 1'b1;
        tag_pa    = line_pa_q;
        st_pa     = line_pa_q;
        bc_pa     = line_pa_q;
        st_way    = way_q;
        st_state  = COH_INVALID;
        done_code = code_e;
    end

    a_r4_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req && xl_ack && (xl_bat_viol || xl_tlb_viol)) |=> (done && !tag_req && !st_we && !bc_req));
    a_r5_dseg_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req && xl_ack && xl_dseg) |=> (done && !tag_req));
    a_r7_miss_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_req && tag_ack && !tag_hit) |=> !st_we);
    a_r6_hit_write: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_req && tag_ack && tag_hit) |=> (st_we && st_way == $past(tag_way)));
endmodule

// File: tb/dcinv_ctrl_tb.sv
module dcinv_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    typedef struct packed {
        logic        bat, tlb, ds, m, hit;
        logic [3:0]  xd, td, bd;
        logic [2:0]  way;
        logic [31:0] pa;
        logic [1:0]  efault;
        logic        elook, ewr, ebc;
    } vec_t;

    // bat tlb ds m hit | xl/tag/bc delays | way | pa | fault look wr bc
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,1'b0,1'b1, 4'd0,4'd0,4'd0, 3'd3, 32'h1234_567F, 2'b00, 1'b1,1'b1,1'b0}, // R6 hit, no M
        '{1'b0,1'b0,1'b0,1'b1,1'b1, 4'd1,4'd1,4'd2, 3'd5, 32'h0000_1020, 2'b00, 1'b1,1'b1,1'b1}, // R8 hit+M
        '{1'b0,1'b0,1'b0,1'b1,1'b0, 4'd0,4'd2,4'd1, 3'd0, 32'hFFFF_FFE3, 2'b00, 1'b1,1'b0,1'b1}, // R7 R8 miss+M
        '{1'b0,1'b0,1'b0,1'b0,1'b0, 4'd2,4'd0,4'd0, 3'd1, 32'h8000_0011, 2'b00, 1'b1,1'b0,1'b0}, // R7 miss
        '{1'b0,1'b0,1'b1,1'b1,1'b1, 4'd1,4'd0,4'd0, 3'd2, 32'h0BAD_0000, 2'b00, 1'b0,1'b0,1'b0}, // R5 dseg
        '{1'b1,1'b0,1'b0,1'b1,1'b1, 4'd0,4'd0,4'd0, 3'd2, 32'h0000_0040, 2'b01, 1'b0,1'b0,1'b0}, // R4 BAT
        '{1'b0,1'b1,1'b0,1'b1,1'b1, 4'd3,4'd0,4'd0, 3'd2, 32'h0000_0080, 2'b10, 1'b0,1'b0,1'b0}, // R4 TLB
        '{1'b1,1'b1,1'b0,1'b0,1'b1, 4'd0,4'd0,4'd0, 3'd2, 32'h0000_00C0, 2'b01, 1'b0,1'b0,1'b0}, // R4 both
        '{1'b0,1'b0,1'b0,1'b1,1'b1, 4'd3,4'd2,4'd4, 3'd7, 32'hA5A5_A5BF, 2'b00, 1'b1,1'b1,1'b1}, // R8 long ack
        '{1'b0,1'b1,1'b1,1'b1,1'b0, 4'd0,4'd0,4'd0, 3'd0, 32'h0000_0100, 2'b10, 1'b0,1'b0,1'b0}  // R4 fault over dseg
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [31:0] req_ea = '0;
    logic req_ready, xl_req, xl_write, xl_ack, tag_req, tag_ack, st_we, bc_req, bc_ack, done;
    logic [31:0] xl_ea, tag_pa, st_pa, bc_pa;
    logic [2:0]  st_way;
    logic [1:0]  st_state, done_code;
    vec_t cur = '0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Responders: acknowledge after the programmed number of waiting cycles.
    int xcnt = 0, tcnt = 0, bcnt = 0;
    assign xl_ack  = xl_req  && (xcnt >= int'(cur.xd));
    assign tag_ack = tag_req && (tcnt >= int'(cur.td));
    assign bc_ack  = bc_req  && (bcnt >= int'(cur.bd));
    always @(posedge clk) begin
        xcnt <= (xl_req  && !xl_ack)  ? xcnt + 1 : 0;
        tcnt <= (tag_req && !tag_ack) ? tcnt + 1 : 0;
        bcnt <= (bc_req  && !bc_ack)  ? bcnt + 1 : 0;
    end

    dcinv_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ea(req_ea), .req_ready(req_ready),
        .xl_req(xl_req), .xl_ea(xl_ea), .xl_write(xl_write), .xl_ack(xl_ack),
        .xl_pa(cur.pa), .xl_coh(cur.m), .xl_dseg(cur.ds),
        .xl_bat_viol(cur.bat), .xl_tlb_viol(cur.tlb),
        .tag_req(tag_req), .tag_pa(tag_pa), .tag_ack(tag_ack),
        .tag_hit(cur.hit), .tag_way(cur.way),
        .st_we(st_we), .st_pa(st_pa), .st_way(st_way), .st_state(st_state),
        .bc_req(bc_req), .bc_pa(bc_pa), .bc_ack(bc_ack),
        .done(done), .done_code(done_code)
    );

    // Monitor: counts strobes and records what each handshake carried.
    int n_xl, n_tag, n_wr, n_bccyc, n_done, n_order, n_wflag;
    logic xl_seen;
    logic [31:0] ea_seen, tagpa_seen, stpa_seen, bcpa_seen;
    logic [2:0]  way_seen;
    logic [1:0]  state_seen, code_seen;
    task automatic mon_clear();
        n_xl = 0; n_tag = 0; n_wr = 0; n_bccyc = 0; n_done = 0; n_order = 0; n_wflag = 0;
        xl_seen = 1'b0; ea_seen = '0; tagpa_seen = '0; stpa_seen = '0; bcpa_seen = '0;
        way_seen = '0; state_seen = 2'b11; code_seen = 2'b11;
    endtask
    always @(negedge clk) if (rst_n) begin
        if (xl_req && !xl_write) n_wflag++;
        if (tag_req && !xl_seen) n_order++;
        if (xl_req && xl_ack) begin n_xl++; xl_seen = 1'b1; ea_seen = xl_ea; end
        if (tag_req && tag_ack) begin n_tag++; tagpa_seen = tag_pa; end
        if (st_we) begin n_wr++; stpa_seen = st_pa; way_seen = st_way; state_seen = st_state; end
        if (bc_req) begin n_bccyc++; bcpa_seen = bc_pa; end
        if (done) begin n_done++; code_seen = done_code; end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input vec_t v, input logic [31:0] ea);
        logic [31:0] line;
        line = v.pa & 32'hFFFF_FFE0;
        @(negedge clk);
        cur = v;
        mon_clear();
        req_valid = 1'b1; req_ea = ea;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 60 && n_done == 0; i++) @(negedge clk);
        #1;
        chk(n_done == 1, "R9 done seen", n_done, 1);
        chk(code_seen == v.efault, "R4 R9 done code", code_seen, v.efault);
        chk(n_xl == 1 && ea_seen == ea, "R3 translate ea", ea_seen, ea);
        chk(n_wflag == 0 && n_order == 0, "R3 write kind/order", n_wflag + n_order, 0);
        chk(n_tag == int'(v.elook), "R4 R5 lookup count", n_tag, v.elook);
        chk(n_wr == int'(v.ewr), "R6 R7 write count", n_wr, v.ewr);
        chk(n_bccyc == (v.ebc ? int'(v.bd) + 1 : 0), "R8 broadcast cycles", n_bccyc, v.ebc ? v.bd + 1 : 0);
        if (v.ewr) chk(state_seen == 2'b00 && way_seen == v.way && stpa_seen == line,
                       "R6 write fields", {state_seen, way_seen, stpa_seen}, {2'b00, v.way, line});
        if (v.elook) chk(tagpa_seen == line, "R10 lookup address", tagpa_seen, line);
        if (v.ebc) chk(bcpa_seen == line, "R10 broadcast address", bcpa_seen, line);
        @(negedge clk);
        chk(!done && req_ready, "R9 single pulse then ready", {done, req_ready}, 2'b01);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        mon_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready && !done && !xl_req && !tag_req && !st_we && !bc_req, "R1 reset state",
            {req_ready, done, xl_req, tag_req, st_we, bc_req}, 6'b100000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !xl_req, "R1 idle after reset", {req_ready, xl_req}, 2'b10);

        for (int k = 0; k < NV; k++) run_op(VECS[k], 32'hC000_0000 + 32'(k * 64));

        // R2: hold req_valid through a busy operation; only one must run.
        begin
            vec_t v;
            v = VECS[8];
            @(negedge clk);
            cur = v;
            mon_clear();
            req_valid = 1'b1; req_ea = 32'h1111_0000;
            @(negedge clk);
            req_ea = 32'h2222_0000;
            for (int i = 0; i < 60 && n_done == 0; i++) @(negedge clk);
            req_valid = 1'b0;
            #1;
            chk(n_xl == 1 && ea_seen == 32'h1111_0000, "R2 busy request ignored", ea_seen, 32'h1111_0000);
            repeat (4) @(negedge clk);
            #1;
            chk(n_done == 1 && n_xl == 1, "R2 one completion", n_done, 1);
        end

        // R1: reset in the middle of an operation returns to idle.
        @(negedge clk);
        cur = VECS[8];
        mon_clear();
        req_valid = 1'b1; req_ea = 32'h3333_0000;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(req_ready && !xl_req && !tag_req && !bc_req && !done, "R1 mid-op reset",
            {req_ready, xl_req, tag_req, bc_req, done}, 5'b10000);
        rst_n = 1'b1;
        run_op(VECS[1], 32'h4444_0000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule